// File: doc/BRIEF.md
# Aliased Wide Vector Register File

This block is the architectural storage for a wide SIMD unit: sixteen 256-bit vector registers, where the low 128 bits of every register double as a narrow 128-bit register. Narrow-width code and wide-width code therefore see one shared store. The narrow view of a register is bits [127:0] of whatever a read port returns for it.

Two independent combinational read ports and one write port allow three-operand operation: two sources are read and a third register is written, so neither source is overwritten. Every write carries a mode. A full write replaces all 256 bits. A preserving narrow write changes only the low half. A zeroing narrow write changes the low half and clears the high half. Two bulk commands act on all registers in one clock: one clears every high half, the other clears every register. A per-register flag marks registers whose high half was loaded by a full write.

Top module: `widesimd_regfile`

## Requirements
- R1: After reset, every register reads as zero on both read ports and `upperDirty` is all zeros.
- R2: A write with `wrMode` = 0 (full) stores all 256 bits of `wrData` into register `wrAddr`. From the next cycle that value appears on either read port that addresses it. A write to one address leaves every other register unchanged, so sources read on the two ports survive a write to a third register.
- R3: A write with `wrMode` = 1 (preserving narrow) stores `wrData[127:0]` into bits [127:0] of the destination and leaves bits [255:128] unchanged.
- R4: A write with `wrMode` = 2 (zeroing narrow) stores `wrData[127:0]` into bits [127:0] of the destination and sets bits [255:128] to zero.
- R5: A write with `wrMode` = 3 has no effect on any register or on `upperDirty`.
- R6: When a read port addresses the register that an effective write targets in the same cycle, that port returns the value the register will hold after the write. Bits [255:128] follow the mode: new data, the stored value, or zero.
- R7: `clrUpper` sets bits [255:128] of all sixteen registers to zero in one cycle and leaves bits [127:0] unchanged.
- R8: `clrAll` sets all 256 bits of all sixteen registers to zero in one cycle.
- R9: When `clrUpper` or `clrAll` is high, any write in the same cycle is discarded and nothing is forwarded to the read ports. During that cycle the read ports return the stored values.
- R10: `upperDirty[i]` is set by an effective full write to register i. Either clear command clears all of these bits. Narrow writes leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 4 | Read port A register index |
| rdDataA | output | 256 | Read port A data; [127:0] is the narrow view |
| rdAddrB | input | 4 | Read port B register index |
| rdDataB | output | 256 | Read port B data; [127:0] is the narrow view |
| wrEn | input | 1 | Write request |
| wrAddr | input | 4 | Destination register index |
| wrMode | input | 2 | 0 full, 1 preserving narrow, 2 zeroing narrow, 3 no write |
| wrData | input | 256 | Write data |
| clrUpper | input | 1 | Clear bits [255:128] of every register |
| clrAll | input | 1 | Clear every register completely |
| upperDirty | output | 16 | Per-register flag: high half loaded by a full write |

## Verification
A corrupted high half, for example one left over after a preserving narrow write, a missed bulk clear, or a write that was not suppressed under a clear, appears on the next read of that register. The bench reads each affected register one cycle after the operation. A fault in the forwarding path shows in the same cycle as the write, because the bench reads the destination while it is being written. A dirty flag that is set or cleared by the wrong event differs from the expected 16-bit vector at the next sample.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

  typedef enum logic [1:0] {
    WM_FULL     = 2'd0,
    WM_LOW_KEEP = 2'd1,
    WM_LOW_ZERO = 2'd2,
    WM_NONE     = 2'd3
  } wrMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrLow;      // load low half of the destination
    logic wrHigh;     // load high half of the destination from data
    logic zeroHigh;   // force high half of the destination to zero
    logic markDirty;  // set the destination dirty flag
    logic clrUpper;   // bulk clear of every high half
    logic clrAll;     // bulk clear of every register
  } vrfStrobe_t;

endpackage

// File: rtl/vrf_ctrl.sv
module vrf_ctrl
  import vrf_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrMode,
  input  logic       clrUpper,
  input  logic       clrAll,
  output vrfStrobe_t strobe
);

  logic bulkActive;
  assign bulkActive = clrUpper | clrAll;

  always_comb begin
    strobe          = '0;
    strobe.clrAll   = clrAll;
    strobe.clrUpper = clrUpper & ~clrAll;
    if (wrEn && !bulkActive) begin
      unique case (wrMode_e'(wrMode))
        WM_FULL: begin
          strobe.wrLow     = 1'b1;
          strobe.wrHigh    = 1'b1;
          strobe.markDirty = 1'b1;
        end
        WM_LOW_KEEP: strobe.wrLow = 1'b1;
        WM_LOW_ZERO: begin
          strobe.wrLow    = 1'b1;
          strobe.zeroHigh = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vrf_datapath.sv
module vrf_datapath
  import vrf_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int FULL_W    = 256,
  parameter int NARROW_W  = 128,
  parameter int NUM_RD    = 2,
  localparam int ADDR_W   = $clog2(NUM_REGS),
  localparam int HIGH_W   = FULL_W - NARROW_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  vrfStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [FULL_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr [NUM_RD],
  output logic [FULL_W-1:0]   rdData [NUM_RD],
  output logic [NUM_REGS-1:0] upperDirty
);

  logic [NARROW_W-1:0] lowHalf  [NUM_REGS];
  logic [HIGH_W-1:0]   highHalf [NUM_REGS];
  logic [HIGH_W-1:0]   wrHighValue;

  assign wrHighValue = strobe.wrHigh ? wrData[FULL_W-1:NARROW_W] : '0;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic isDest;
    assign isDest = (wrAddr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lowHalf[i]    <= '0;
        highHalf[i]   <= '0;
        upperDirty[i] <= 1'b0;
      end else if (strobe.clrAll) begin
        lowHalf[i]    <= '0;
        highHalf[i]   <= '0;
        upperDirty[i] <= 1'b0;
      end else if (strobe.clrUpper) begin
        highHalf[i]   <= '0;
        upperDirty[i] <= 1'b0;
      end else if (isDest) begin
        if (strobe.wrLow) lowHalf[i] <= wrData[NARROW_W-1:0];
        if (strobe.wrHigh || strobe.zeroHigh) highHalf[i] <= wrHighValue;
        if (strobe.markDirty) upperDirty[i] <= 1'b1;
      end
    end
  end

  // Combinational read with same-cycle write forwarding
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic hit;
    assign hit = strobe.wrLow && (rdAddr[p] == wrAddr);
    always_comb begin
      rdData[p] = {highHalf[rdAddr[p]], lowHalf[rdAddr[p]]};
      if (hit) begin
        rdData[p][NARROW_W-1:0] = wrData[NARROW_W-1:0];
        if (strobe.wrHigh || strobe.zeroHigh)
          rdData[p][FULL_W-1:NARROW_W] = wrHighValue;
      end
    end
  end

endmodule

// File: rtl/widesimd_regfile.sv
module widesimd_regfile
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int FULL_W   = 256,
  parameter int NARROW_W = 128,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   rdAddrA,
  output logic [FULL_W-1:0]   rdDataA,
  input  logic [ADDR_W-1:0]   rdAddrB,
  output logic [FULL_W-1:0]   rdDataB,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [1:0]          wrMode,
  input  logic [FULL_W-1:0]   wrData,
  input  logic                clrUpper,
  input  logic                clrAll,
  output logic [NUM_REGS-1:0] upperDirty
);

  vrfStrobe_t        strobe;
  logic [ADDR_W-1:0] rdAddr [2];
  logic [FULL_W-1:0] rdData [2];

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  vrf_ctrl ctrl_i (
    .wrEn     (wrEn),
    .wrMode   (wrMode),
    .clrUpper (clrUpper),
    .clrAll   (clrAll),
    .strobe   (strobe)
  );

  vrf_datapath #(
    .NUM_REGS (NUM_REGS),
    .FULL_W   (FULL_W),
    .NARROW_W (NARROW_W),
    .NUM_RD   (2)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .upperDirty (upperDirty)
  );

endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
  parameter int NUM_REGS = 16,
  parameter int FULL_W   = 256,
  parameter int NARROW_W = 128,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   rdAddrA,
  input logic [FULL_W-1:0]   rdDataA,
  input logic [ADDR_W-1:0]   rdAddrB,
  input logic [FULL_W-1:0]   rdDataB,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   wrAddr,
  input logic [1:0]          wrMode,
  input logic [FULL_W-1:0]   wrData,
  input logic                clrUpper,
  input logic                clrAll,
  input logic [NUM_REGS-1:0] upperDirty
);

  logic anyClr;
  assign anyClr = clrUpper | clrAll;

  assert_full_write_stored_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn && wrMode == 2'd0 && !anyClr) && !wrEn && rdAddrA == $past(wrAddr))
      |-> rdDataA == $past(wrData));

  assert_zero_narrow_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn && wrMode == 2'd2 && !anyClr) && !wrEn && rdAddrA == $past(wrAddr))
      |-> rdDataA[FULL_W-1:NARROW_W] == '0);

  assert_idle_mode_no_dirty_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && wrMode == 2'd3 && !anyClr) |-> upperDirty == $past(upperDirty));

  assert_clear_upper_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clrUpper) && !(wrEn && wrAddr == rdAddrB))
      |-> rdDataB[FULL_W-1:NARROW_W] == '0);

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clrAll) && !(wrEn && wrAddr == rdAddrA))
      |-> (rdDataA == '0 && upperDirty == '0));

  assert_dirty_on_full_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && wrMode == 2'd0 && !anyClr) |-> upperDirty[$past(wrAddr)]);

endmodule

bind widesimd_regfile vrf_checker #(
  .NUM_REGS (NUM_REGS),
  .FULL_W   (FULL_W),
  .NARROW_W (NARROW_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .rdAddrA    (rdAddrA),
  .rdDataA    (rdDataA),
  .rdAddrB    (rdAddrB),
  .rdDataB    (rdDataB),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrMode     (wrMode),
  .wrData     (wrData),
  .clrUpper   (clrUpper),
  .clrAll     (clrAll),
  .upperDirty (upperDirty)
);

// File: tb/widesimd_regfile_tb_top.sv
module widesimd_regfile_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [255:0] rdDataA, rdDataB, wrData = '0;
  logic         wrEn = 1'b0, clrUpper = 1'b0, clrAll = 1'b0;
  logic [1:0]   wrMode = 2'd0;
  logic [15:0]  upperDirty;

  always #4 clk = ~clk;  // 125 MHz

  widesimd_regfile dut_i (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrMode(wrMode), .wrData(wrData),
    .clrUpper(clrUpper), .clrAll(clrAll), .upperDirty(upperDirty)
  );

  typedef struct {
    string        tag;
    logic [255:0] expA;
    logic [255:0] expB;
    logic [15:0]  expDirty;
  } expItem_t;

  expItem_t     sbQueue[$];
  logic [255:0] model [16];
  logic [15:0]  modelDirty;
  int           testCount = 0;
  int           failCount = 0;
  bit           done = 1'b0;

  function automatic logic [255:0] pat(input int seed);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) r[w*32 +: 32] = 32'h9E37_79B9 * (seed + 1) + 32'(w * 32'h0101_0101);
    return r;
  endfunction

  // Expected read value per the requirements (forwarding and clear priority)
  function automatic logic [255:0] expRead(input logic [3:0] ra);
    logic [255:0] v;
    v = model[ra];
    if (wrEn && !clrUpper && !clrAll && ra == wrAddr && wrMode != 2'd3) begin
      v[127:0] = wrData[127:0];
      if (wrMode == 2'd0) v[255:128] = wrData[255:128];
      else if (wrMode == 2'd2) v[255:128] = '0;
    end
    return v;
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected sample
  task automatic step(input string tag, input logic en, input logic [1:0] mode,
                      input logic [3:0] wa, input logic [255:0] wd,
                      input logic cu, input logic ca,
                      input logic [3:0] ra, input logic [3:0] rb);
    expItem_t it;
    @(negedge clk);
    wrEn = en; wrMode = mode; wrAddr = wa; wrData = wd;
    clrUpper = cu; clrAll = ca; rdAddrA = ra; rdAddrB = rb;
    it.tag = tag; it.expA = expRead(ra); it.expB = expRead(rb); it.expDirty = modelDirty;
    sbQueue.push_back(it);
    @(posedge clk);
    if (ca) begin
      for (int i = 0; i < 16; i++) model[i] = '0;
      modelDirty = '0;
    end else if (cu) begin
      for (int i = 0; i < 16; i++) model[i][255:128] = '0;
      modelDirty = '0;
    end else if (en && mode != 2'd3) begin
      model[wa][127:0] = wd[127:0];
      if (mode == 2'd0) begin
        model[wa][255:128] = wd[255:128];
        modelDirty[wa] = 1'b1;
      end else if (mode == 2'd2) model[wa][255:128] = '0;
    end
  endtask

  // Monitor: pops expected items and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbQueue.size() > 0) begin
        expItem_t it;
        it = sbQueue.pop_front();
        testCount++;
        if (rdDataA !== it.expA || rdDataB !== it.expB || upperDirty !== it.expDirty) begin
          failCount++;
          $display("FAIL %s: A=%h B=%h dirty=%h expected A=%h B=%h dirty=%h",
                   it.tag, rdDataA, rdDataB, upperDirty, it.expA, it.expB, it.expDirty);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    modelDirty = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    step("R1 reset",            0, 2'd0, 4'd0,  '0,     0, 0, 4'd0, 4'd15);
    step("R2 R6 full fwd",      1, 2'd0, 4'd3,  pat(1), 0, 0, 4'd3, 4'd5);
    step("R2 R10 full stored",  0, 2'd0, 4'd0,  '0,     0, 0, 4'd3, 4'd3);
    step("R2 third dest",       1, 2'd0, 4'd5,  pat(2), 0, 0, 4'd3, 4'd5);
    step("R3 R6 keep fwd",      1, 2'd1, 4'd3,  pat(3), 0, 0, 4'd3, 4'd5);
    step("R3 R10 keep stored",  0, 2'd0, 4'd0,  '0,     0, 0, 4'd3, 4'd5);
    step("R4 R6 zero fwd",      1, 2'd2, 4'd5,  pat(4), 0, 0, 4'd3, 4'd5);
    step("R4 zero stored",      0, 2'd0, 4'd0,  '0,     0, 0, 4'd5, 4'd3);
    step("R5 mode3 no fwd",     1, 2'd3, 4'd3,  pat(5), 0, 0, 4'd3, 4'd5);
    step("R5 mode3 ignored",    0, 2'd0, 4'd0,  '0,     0, 0, 4'd3, 4'd5);
    step("R9 clrUpper vs wr",   1, 2'd0, 4'd7,  pat(6), 1, 0, 4'd7, 4'd3);
    step("R7 R9 after clrUp",   0, 2'd0, 4'd0,  '0,     0, 0, 4'd3, 4'd7);
    step("R10 full r9",         1, 2'd0, 4'd9,  pat(7), 0, 0, 4'd9, 4'd3);
    step("R10 full r10",        1, 2'd0, 4'd10, pat(8), 0, 0, 4'd9, 4'd10);
    step("R9 clrAll vs wr",     1, 2'd1, 4'd9,  pat(9), 0, 1, 4'd9, 4'd10);
    step("R8 after clrAll",     0, 2'd0, 4'd0,  '0,     0, 0, 4'd9, 4'd10);
    step("R8 low cleared",      0, 2'd0, 4'd0,  '0,     0, 0, 4'd3, 4'd5);
    step("R3 keep on clean",    1, 2'd1, 4'd12, pat(10),0, 0, 4'd12, 4'd0);
    step("R3 keep stored",      0, 2'd0, 4'd0,  '0,     0, 0, 4'd12, 4'd15);

    @(negedge clk);
    #3;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule